// File: doc/BRIEF.md
# Reduced-Rate Two-Stage Synchronizer

This block carries a single asynchronous input bit into a clocked domain. The bit passes through two registers in series, but neither register loads on every system clock edge. A free-running modulo-N counter raises a one-cycle load enable once every N clock cycles, and both registers update only on that cycle. A first-stage register that goes metastable therefore has close to N clock periods, less the setup time, to settle before the second stage samples it. That is longer than the single period a conventional two-register synchronizer allows.

The design uses the single system clock throughout. No divided clock is generated, so the load enable is an ordinary synchronous enable. The parameter `DIV_N` sets how often sampling occurs. A larger value lengthens the settling window and improves the mean time between failures, at the cost of more latency. When `DIV_N` is 1 the enable is always high and the block acts as a plain two-register synchronizer.

Each register is written as a two-state level machine with the states `LVL_LOW` and `LVL_HIGH`. On a load cycle the machine moves `LVL_LOW -> LVL_HIGH` when its data input is 1 and `LVL_HIGH -> LVL_LOW` when its data input is 0. On any other cycle it stays in its current state.

Top module: `rr_sync`

## Requirements
- R1: While `rst_n` is low (active-low, asynchronous), the counter is cleared and `sync_out` is 0. `sync_out` remains 0 after release for as long as `async_in` stays 0.
- R2: The internal counter runs 0, 1, ..., DIV_N-1 and then wraps to 0. The load enable is high only when the count equals DIV_N-1, which makes it high for exactly one cycle in every DIV_N. Numbering the rising edges after reset release from 1, the loads happen on edges DIV_N, 2*DIV_N, and so on.
- R3: `sync_out` can change only on a load edge, meaning an edge whose number is a multiple of DIV_N.
- R4: The first stage captures `async_in` only on load edges. An input pulse that starts and ends between two consecutive load edges has no effect on `sync_out`.
- R5: On a load edge the second stage takes the value the first stage held just before that edge. A level that `async_in` (active-high) holds at load edge L therefore appears on `sync_out` at edge L+DIV_N.
- R6: Once `async_in` has been stable for 2*DIV_N edges, `sync_out` equals `async_in`. This worst case occurs when the input changes just after a load edge.
- R7: With DIV_N = 1, every edge is a load edge. `sync_out` then follows `async_in` exactly two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| async_in | input | 1 | Input bit that is not related to clk |
| sync_out | output | 1 | Synchronized copy of async_in |

## Verification
On every cycle, the bound checker confirms the spacing of the load enable: it never arrives earlier or later than DIV_N cycles after the previous one. It also confirms that both stages hold their values on cycles without a load, that each stage loads its predecessor's value on a load cycle, and that reset clears the output. Only the bench scenarios can demonstrate end-to-end timing seen from the ports. These scenarios cover the exact latency when the input changes just before or just after a load edge, a short pulse that falls between load edges and is swallowed, the two-edge delay of the DIV_N = 1 variant, and a long run of input changes at random times. During that run a monitor confirms that output changes fall only on load edges and that the 2*DIV_N bound always holds.

// File: rtl/rr_sync_pkg.sv
package rr_sync_pkg;

    // Number of registers in the synchronizing chain.
    localparam int SYNC_STAGES = 2;

    // Level held by one synchronizing register.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_t;

endpackage

// File: rtl/rr_sync_divider.sv
module rr_sync_divider #(
    parameter int DIV_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_en
);

    // A one-bit counter is kept for DIV_N = 1; it then sits at 0 forever.
    localparam int CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = at_last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        load_en = at_last;
    end

endmodule

// File: rtl/rr_sync_stage.sv
module rr_sync_stage
    import rr_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic d,
    output logic q
);

    level_t state_q;
    level_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: move only on a load cycle
    always_comb begin
        state_d = state_q;
        if (load_en) begin
            unique case (state_q)
                LVL_LOW:  if (d)  state_d = LVL_HIGH;
                LVL_HIGH: if (!d) state_d = LVL_LOW;
            endcase
        end
    end

    // Output
    always_comb begin
        q = (state_q == LVL_HIGH);
    end

endmodule

// File: rtl/rr_sync.sv
module rr_sync
    import rr_sync_pkg::*;
#(
    parameter int DIV_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic                   load_en;
    logic [SYNC_STAGES:0]   chain;
    logic                   meta_q;

    rr_sync_divider #(
        .DIV_N (DIV_N)
    ) u_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en)
    );

    always_comb begin
        chain[0] = async_in;
    end

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gen_stage
        rr_sync_stage u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en),
            .d       (chain[i]),
            .q       (chain[i+1])
        );
    end

    always_comb begin
        meta_q   = chain[1];
        sync_out = chain[SYNC_STAGES];
    end

endmodule

// File: rtl/rr_sync_chk.sv
module rr_sync_chk #(
    parameter int DIV_N = 4
) (
    input logic clk,
    input logic rst_n,
    input logic async_in,
    input logic sync_out,
    input logic load_en,
    input logic meta_q
);

    // Cycles since the last load enable, counted independently of the divider.
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (load_en) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    // R2: the enable never arrives early
    assert_load_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (gap_q == DIV_N - 1));

    // R2: the enable is never skipped
    assert_load_not_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q >= DIV_N - 1) |-> load_en);

    // R3: output holds between load edges
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(sync_out));

    // R4: first stage holds between load edges
    assert_meta_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(meta_q));

    // R4: first stage captures the input on a load edge
    assert_meta_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (meta_q == $past(async_in)));

    // R5: second stage takes the first stage value on a load edge
    assert_stage_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sync_out == $past(meta_q)));

    // R1: reset clears the output
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (sync_out == 1'b0));

endmodule

bind rr_sync rr_sync_chk #(
    .DIV_N (DIV_N)
) u_rr_sync_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (async_in),
    .sync_out (sync_out),
    .load_en  (load_en),
    .meta_q   (meta_q)
);

// File: tb/rr_sync_bench.sv
`timescale 1ns/1ps
module rr_sync_bench;

    localparam int NS [2] = '{4, 1};
    localparam int WATCHDOG_CYCLES = 40000;

    logic clk = 1'b0;
    logic rst_n;
    logic async_in;
    logic out_w [2];

    int edge_n = 0;
    int mon_total = 0;
    int mon_fail = 0;
    int dir_total = 0;
    int dir_fail = 0;
    int wd_fail = 0;
    int since = 0;
    logic last_in;
    logic prev_out [2];

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < 2; g++) begin : gen_dut
        rr_sync #(
            .DIV_N (NS[g])
        ) u_rr_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (async_in),
            .sync_out (out_w[g])
        );
    end

    // Rising edges since reset release, numbered from 1
    always @(posedge clk) begin
        if (rst_n === 1'b1) edge_n <= edge_n + 1;
    end

    // Continuous monitor: R3 change placement and R6 latency bound
    always @(negedge clk) begin
        if (rst_n !== 1'b1) begin
            since = 0;
            last_in = async_in;
            for (int g = 0; g < 2; g++) prev_out[g] = out_w[g];
        end else begin
            if (async_in !== last_in) begin
                last_in = async_in;
                since = 0;
            end else begin
                since++;
            end
            for (int g = 0; g < 2; g++) begin
                if (out_w[g] !== prev_out[g]) begin
                    mon_total++;
                    if (edge_n % NS[g] != 0) begin
                        mon_fail++;
                        $display("FAIL R3 N=%0d: output changed at edge %0d, actual edge mod N=%0d expected 0",
                                 NS[g], edge_n, edge_n % NS[g]);
                    end
                end
                if (since >= 2 * NS[g]) begin
                    mon_total++;
                    if (out_w[g] !== async_in) begin
                        mon_fail++;
                        $display("FAIL R6 N=%0d: stable for %0d edges, actual %b expected %b",
                                 NS[g], since, out_w[g], async_in);
                    end
                end
                prev_out[g] = out_w[g];
            end
        end
    end

    task automatic dchk(input string tag, input logic act, input logic exp);
        dir_total++;
        if (act !== exp) begin
            dir_fail++;
            $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, edge_n);
        end
    endtask

    // Leave the task 1 ns after an edge whose number mod 4 equals r
    task automatic align4(input int r);
        do begin
            @(posedge clk);
            #1;
        end while (edge_n % 4 != r);
    endtask

    task automatic finish_run;
        int total;
        int failed;
        total  = mon_total + dir_total + wd_fail;
        failed = mon_fail + dir_fail + wd_fail;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        async_in = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        dchk("R1 reset N=4", out_w[0], 1'b0);
        dchk("R1 reset N=1", out_w[1], 1'b0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: output stays low after release with input low
        repeat (10) @(posedge clk);
        #2;
        dchk("R1 idle N=4", out_w[0], 1'b0);
        dchk("R1 idle N=1", out_w[1], 1'b0);

        // R5/R2: rise just before a load edge -> out at that edge + N
        align4(3);
        async_in = 1'b1;
        repeat (4) @(posedge clk);
        #2 dchk("R5 before second load", out_w[0], 1'b0);
        @(posedge clk);
        #2 dchk("R5 at second load", out_w[0], 1'b1);

        // R6: fall just after a load edge -> worst case 2N edges
        align4(0);
        async_in = 1'b0;
        repeat (7) @(posedge clk);
        #2 dchk("R6 edge 2N-1", out_w[0], 1'b1);
        @(posedge clk);
        #2 dchk("R6 edge 2N", out_w[0], 1'b0);

        // R7: DIV_N=1 follows two edges later
        @(posedge clk);
        #1 async_in = 1'b1;
        @(posedge clk);
        #2 dchk("R7 one edge", out_w[1], 1'b0);
        @(posedge clk);
        #2 dchk("R7 two edges", out_w[1], 1'b1);

        // R4: low pulse between two load edges is swallowed
        repeat (10) @(posedge clk);
        #2 dchk("R4 settled high", out_w[0], 1'b1);
        align4(0);
        async_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 async_in = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            #2 dchk("R4 pulse ignored", out_w[0], 1'b1);
        end

        // Random-time sweep, checked by the monitor (R3, R6)
        for (int i = 0; i < 400; i++) begin
            repeat ($urandom_range(1, 12)) @(posedge clk);
            #1 async_in = 1'($urandom_range(0, 1));
        end
        repeat (20) @(posedge clk);
        #2;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        wd_fail = 1;
        $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", WATCHDOG_CYCLES);
        finish_run();
    end

endmodule